// File: doc/BRIEF.md
# Supervisor memory protection checker

This block decides, within the same cycle, whether a supervisor-mode physical access may proceed. It compares one byte address and one access kind (load, store or instruction fetch) against a parameterised set of protection entries. Each entry has an eight-bit configuration byte and an address register, and both come from a register bank that lies outside the block. The block only sees accesses that the machine-level protection stage has already judged, and it can only narrow that verdict, never widen it.

An entry takes part only when its switch bit is set and its match mode is non-zero. A four-byte mode matches one aligned word. A power-of-two mode takes its size from the trailing ones of the address register. Among the entries that match, the lowest-numbered one decides. A supervisor access that matches no entry is refused, and machine-mode accesses pass straight through with the machine-level verdict. Besides the verdict, the block reports whether any entry matched and which entry won, for use by trap and debug logic.

Top module: `smpu_access_check`

## Requirements
- R1: An entry takes part in matching only when its bit in `entry_on` is 1 and its mode field (configuration bits 4:3) is non-zero. Otherwise it never matches.
- R2: Mode 2 (four-byte) matches exactly the bytes whose address, shifted right by 2, equals the address register.
- R3: Mode 3 (power-of-two) counts t, the trailing ones of the address register. It matches the 2^(t+3)-byte region whose base is the register with its low t bits cleared, shifted left by 2. An all-ones register matches every address.
- R4: Mode 1 (bounded-range) is treated as no match.
- R5: When several active entries match, `hit_idx` names the lowest-numbered one and only its permissions decide. `hit_any` is 1 exactly when some active entry matches, and `hit_idx` is 0 when none does.
- R6: A supervisor access (`sup_mode`=1) that matches no active entry is refused.
- R7: A matched supervisor access is granted only when the winning entry allows its kind: `acc_kind` 00 = load needs bit 0, 01 = store needs bit 1, 10 = fetch needs bit 2. Kind 11 is always refused.
- R8: A machine-mode access (`sup_mode`=0) gets `grant` equal to `mach_ok`, whatever the entries hold.
- R9: When `mach_ok` is 0, `grant` is 0 in every mode.
- R10: Configuration bits 7:5 (lock, user and spare) have no effect on `grant`, `hit_any` or `hit_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phys_addr | input | PA_W (32) | Byte address of the access |
| acc_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 reserved |
| sup_mode | input | 1 | 1 for a supervisor access, 0 for machine mode |
| mach_ok | input | 1 | Machine-level protection stage allowed the access |
| entry_on | input | NENT (16) | Per-entry switch bits |
| cfg_flat | input | 8*NENT | Configuration bytes; entry i in bits 8i+7:8i |
| areg_flat | input | (PA_W-2)*NENT | Address registers; entry i in slice i |
| grant | output | 1 | Access may proceed |
| hit_any | output | 1 | Some active entry matches the address |
| hit_idx | output | log2(NENT) | Lowest-numbered matching active entry |

## Verification
Two functions meet in one cycle when overlapping entries match the same address: the priority pick and the permission check must then use the lower entry's rights even where a higher entry would grant. The bench sets up a power-of-two region holding a four-byte entry with broader rights, stores into the overlap and expects a refusal, then switches the lower entry off and expects the higher entry to win. The machine-level veto also meets a granting entry: the bench keeps a fully permissive match and drops `mach_ok`, and expects `grant` to fall while `hit_any` and `hit_idx` still report the match. A seeded random sweep then compares every output against a model in the bench that counts trailing ones with a loop.

// File: rtl/smpu_pkg.sv
package smpu_pkg;

  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_RANGE = 2'd1,
    AM_WORD  = 2'd2,
    AM_POW2  = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  // configuration byte layout decoded by this block and the register bank
  typedef struct packed {
    logic   lck;
    logic   usr;
    logic   spare;
    amode_e mode;
    logic   x;
    logic   w;
    logic   r;
  } ecfg_t;

  localparam int unsigned WIDE = 64;

  // Word-address bits a power-of-two region ignores: bits 0..t, where t is
  // the number of trailing ones. The carry of a+1 stops at the first zero.
  function automatic logic [WIDE-1:0] pow2_ignore(input logic [WIDE-1:0] a);
    return a ^ (a + {{(WIDE-1){1'b0}}, 1'b1});
  endfunction

  function automatic logic kind_allowed(input ecfg_t c, input acc_e k);
    case (k)
      ACC_LOAD:  return c.r;
      ACC_STORE: return c.w;
      ACC_FETCH: return c.x;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic amode_e mode_of(input ecfg_t c);
    return c.mode;
  endfunction

endpackage

// File: rtl/smpu_entry_match.sv
module smpu_entry_match
  import smpu_pkg::*;
#(
  parameter int unsigned PA_W = 32,
  localparam int unsigned AW  = PA_W - 2
) (
  input  logic            on_bit,
  input  logic [7:0]      cfg_byte,
  input  logic [AW-1:0]   areg,
  input  logic [PA_W-1:0] addr,
  input  logic [1:0]      kind,
  output logic            hit,
  output logic            allow
);

  amode_e          mode;
  logic            active;
  logic [AW-1:0]   ign_w;
  logic [PA_W-1:0] ign_b;
  logic [PA_W-1:0] diff;
  logic            word_hit;
  logic            pow2_hit;

  assign mode   = mode_of(ecfg_t'(cfg_byte));
  assign active = on_bit && (mode != AM_OFF);

  assign ign_w  = AW'(pow2_ignore(WIDE'(areg)));
  assign ign_b  = {ign_w, 2'b11};
  assign diff   = addr ^ {areg, 2'b00};

  assign word_hit = (diff[PA_W-1:2] == '0);
  assign pow2_hit = ((diff & ~ign_b) == '0);

  always_comb begin
    case (mode)
      AM_WORD: hit = active && word_hit;
      AM_POW2: hit = active && pow2_hit;
      default: hit = 1'b0;
    endcase
  end

  assign allow = kind_allowed(ecfg_t'(cfg_byte), acc_e'(kind));

  always_comb begin
    if (!$isunknown({on_bit, cfg_byte, hit})) begin
      if (!active) assert_inactive_silent_R1: assert (!hit);
      if (mode == AM_RANGE) assert_range_mode_never_hits_R4: assert (!hit);
      if (hit && mode == AM_POW2) assert_pow2_covers_word_R3: assert (pow2_hit);
    end
  end

endmodule

// File: rtl/smpu_prio_pick.sv
module smpu_prio_pick #(
  parameter int unsigned NENT = 16,
  localparam int unsigned IW  = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic [NENT-1:0] hits,
  output logic            any,
  output logic [IW-1:0]   idx
);

  always_comb begin
    idx = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (hits[i]) idx = IW'(i);
    end
  end

  assign any = |hits;

  logic [NENT-1:0] below;
  assign below = (NENT'(1) << idx) - NENT'(1);

  always_comb begin
    if (!$isunknown(hits)) begin
      if (any) begin
        assert_winner_hit_R5: assert (hits[idx]);
        assert_lowest_wins_R5: assert ($countones(hits & below) == 0);
      end else begin
        assert_idle_idx_zero_R5: assert (idx == '0);
      end
    end
  end

endmodule

// File: rtl/smpu_access_check.sv
module smpu_access_check
  import smpu_pkg::*;
#(
  parameter int unsigned NENT = 16,
  parameter int unsigned PA_W = 32,
  localparam int unsigned AW  = PA_W - 2,
  localparam int unsigned IW  = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic [PA_W-1:0]    phys_addr,
  input  logic [1:0]         acc_kind,
  input  logic               sup_mode,
  input  logic               mach_ok,
  input  logic [NENT-1:0]    entry_on,
  input  logic [8*NENT-1:0]  cfg_flat,
  input  logic [AW*NENT-1:0] areg_flat,
  output logic               grant,
  output logic               hit_any,
  output logic [IW-1:0]      hit_idx
);

  logic [NENT-1:0] ent_hit;
  logic [NENT-1:0] ent_allow;

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    smpu_entry_match #(.PA_W(PA_W)) u_match (
      .on_bit   (entry_on[g]),
      .cfg_byte (cfg_flat[8*g +: 8]),
      .areg     (areg_flat[AW*g +: AW]),
      .addr     (phys_addr),
      .kind     (acc_kind),
      .hit      (ent_hit[g]),
      .allow    (ent_allow[g])
    );
  end

  smpu_prio_pick #(.NENT(NENT)) u_pick (
    .hits (ent_hit),
    .any  (hit_any),
    .idx  (hit_idx)
  );

  // named events for the checks below
  logic winner_allows;
  logic sup_verdict;

  assign winner_allows = ent_allow[hit_idx];
  assign sup_verdict   = hit_any && winner_allows;
  assign grant         = mach_ok && (sup_mode ? sup_verdict : 1'b1);

  always_comb begin
    if (!$isunknown({grant, mach_ok, sup_mode, hit_any, acc_kind})) begin
      if (grant) assert_mach_veto_R9: assert (mach_ok);
      if (grant && sup_mode) assert_needs_match_R6: assert (hit_any);
      if (!sup_mode) assert_mmode_bypass_R8: assert (grant == mach_ok);
      if (sup_mode && acc_kind == 2'b11) assert_rsvd_kind_R7: assert (!grant);
    end
  end

endmodule

// File: tb/smpu_access_check_bench.sv
module smpu_access_check_bench;

  localparam int NENT = 16;
  localparam int PA_W = 32;
  localparam int AW   = PA_W - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [PA_W-1:0]    phys_addr;
  logic [1:0]         acc_kind;
  logic               sup_mode;
  logic               mach_ok;
  logic [NENT-1:0]    entry_on;
  logic [8*NENT-1:0]  cfg_flat;
  logic [AW*NENT-1:0] areg_flat;
  logic               grant;
  logic               hit_any;
  logic [3:0]         hit_idx;

  logic [7:0]    bcfg [NENT];
  logic [AW-1:0] bar  [NENT];

  always_comb begin
    for (int i = 0; i < NENT; i++) begin
      cfg_flat[8*i +: 8]    = bcfg[i];
      areg_flat[AW*i +: AW] = bar[i];
    end
  end

  smpu_access_check u_smpu_access_check (
    .phys_addr (phys_addr),
    .acc_kind  (acc_kind),
    .sup_mode  (sup_mode),
    .mach_ok   (mach_ok),
    .entry_on  (entry_on),
    .cfg_flat  (cfg_flat),
    .areg_flat (areg_flat),
    .grant     (grant),
    .hit_any   (hit_any),
    .hit_idx   (hit_idx)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // cfg encodings: bit0 R, bit1 W, bit2 X, bits4:3 mode
  localparam logic [7:0] C_WORD_RWX = 8'h17;
  localparam logic [7:0] C_POW2_RWX = 8'h1F;
  localparam logic [7:0] C_POW2_R   = 8'h19;
  localparam logic [7:0] C_WORD_RW  = 8'h13;
  localparam logic [7:0] C_RANGE    = 8'h0F;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  // independent reference: trailing ones counted with a loop
  task automatic model(output logic g, output logic h, output logic [3:0] ix);
    logic found;
    found = 0; g = 0; h = 0; ix = 0;
    for (int i = 0; i < NENT; i++) begin
      logic m;
      logic [1:0] md;
      md = bcfg[i][4:3];
      m = 0;
      if (entry_on[i] && md == 2'd2) m = (phys_addr[PA_W-1:2] == bar[i]);
      if (entry_on[i] && md == 2'd3) begin
        int t;
        t = 0;
        while (t < AW && bar[i][t]) t++;
        if (t + 1 >= AW) m = 1;
        else m = ((phys_addr[PA_W-1:2] >> (t + 1)) == (bar[i] >> (t + 1)));
      end
      if (m && !found) begin
        found = 1; ix = 4'(i);
        case (acc_kind)
          2'd0: g = bcfg[i][0];
          2'd1: g = bcfg[i][1];
          2'd2: g = bcfg[i][2];
          default: g = 0;
        endcase
      end
    end
    h = found;
    if (!sup_mode) g = 1;
    g = g & mach_ok;
  endtask

  task automatic probe(input string tag, input logic [31:0] a, input logic [1:0] k,
                       input logic s, input logic mok);
    logic eg, eh;
    logic [3:0] ei;
    phys_addr = a; acc_kind = k; sup_mode = s; mach_ok = mok;
    @(negedge clk);
    model(eg, eh, ei);
    chk({tag, " grant"}, 32'(grant), 32'(eg));
    chk({tag, " hit_any"}, 32'(hit_any), 32'(eh));
    chk({tag, " hit_idx"}, 32'(hit_idx), 32'(ei));
  endtask

  task automatic clear_all();
    for (int i = 0; i < NENT; i++) begin bcfg[i] = 8'h00; bar[i] = '0; end
    entry_on = '0;
  endtask

  task automatic t_reset();
    clear_all();
    probe("R6 empty load", 32'h0000_1000, 2'd0, 1, 1);
    chk("R6 empty grant", 32'(grant), 0);
    chk("R5 empty idx", 32'(hit_idx), 0);
  endtask

  task automatic t_switch();
    clear_all();
    bcfg[3] = C_WORD_RWX; bar[3] = 30'h100;
    probe("R1 switch off", 32'h400, 2'd0, 1, 1);
    chk("R1 switch off hit", 32'(hit_any), 0);
    entry_on[3] = 1;
    probe("R1 switch on", 32'h400, 2'd0, 1, 1);
    chk("R1 switch on idx", 32'({hit_any, hit_idx}), 32'h13);
    bcfg[3] = 8'h07;
    probe("R1 mode off", 32'h400, 2'd0, 1, 1);
    chk("R1 mode off hit", 32'(hit_any), 0);
  endtask

  task automatic t_word();
    clear_all();
    bcfg[0] = C_WORD_RWX; bar[0] = 30'h100; entry_on[0] = 1;
    probe("R2 first byte", 32'h400, 2'd1, 1, 1);
    chk("R2 first byte grant", 32'(grant), 1);
    probe("R2 last byte", 32'h403, 2'd2, 1, 1);
    chk("R2 last byte grant", 32'(grant), 1);
    probe("R2 above", 32'h404, 2'd0, 1, 1);
    chk("R2 above hit", 32'(hit_any), 0);
    probe("R2 below", 32'h3FC, 2'd0, 1, 1);
    chk("R2 below hit", 32'(hit_any), 0);
  endtask

  task automatic t_pow2();
    clear_all();
    bcfg[4] = C_POW2_RWX; bar[4] = 30'h403; entry_on[4] = 1;
    probe("R3 base", 32'h1000, 2'd0, 1, 1);
    chk("R3 base hit", 32'(hit_any), 1);
    probe("R3 top", 32'h101F, 2'd0, 1, 1);
    chk("R3 top hit", 32'(hit_any), 1);
    probe("R3 past top", 32'h1020, 2'd0, 1, 1);
    chk("R3 past top hit", 32'(hit_any), 0);
    probe("R3 before base", 32'h0FFC, 2'd0, 1, 1);
    chk("R3 before base hit", 32'(hit_any), 0);
    bar[4] = 30'h400;
    probe("R3 t=0 second word", 32'h1004, 2'd0, 1, 1);
    chk("R3 t=0 eight bytes", 32'(hit_any), 1);
    probe("R3 t=0 third word", 32'h1008, 2'd0, 1, 1);
    chk("R3 t=0 outside", 32'(hit_any), 0);
    bar[4] = '1;
    probe("R3 all ones", 32'hFFFF_FFF0, 2'd0, 1, 1);
    chk("R3 all ones hit", 32'(hit_any), 1);
  endtask

  task automatic t_range();
    clear_all();
    bcfg[1] = C_RANGE; bar[1] = 30'h100; entry_on[1] = 1;
    probe("R4 range", 32'h400, 2'd0, 1, 1);
    chk("R4 range hit", 32'(hit_any), 0);
    chk("R4 range grant", 32'(grant), 0);
  endtask

  task automatic t_prio();
    clear_all();
    bcfg[2] = C_POW2_R;  bar[2] = 30'h403; entry_on[2] = 1;
    bcfg[5] = C_WORD_RW; bar[5] = 30'h402; entry_on[5] = 1;
    bcfg[1] = C_WORD_RWX; bar[1] = 30'h402;
    probe("R5 overlap store", 32'h1008, 2'd1, 1, 1);
    chk("R5 overlap store", 32'({grant, hit_idx}), 32'h02);
    probe("R5 overlap load", 32'h1008, 2'd0, 1, 1);
    chk("R5 overlap load", 32'({grant, hit_idx}), 32'h12);
    entry_on[2] = 0;
    probe("R5 upper wins", 32'h1008, 2'd1, 1, 1);
    chk("R5 upper wins", 32'({grant, hit_idx}), 32'h15);
  endtask

  task automatic t_perm();
    clear_all();
    bcfg[7] = 8'h11; bar[7] = 30'h200; entry_on[7] = 1;
    bcfg[8] = 8'h12; bar[8] = 30'h201; entry_on[8] = 1;
    bcfg[9] = 8'h14; bar[9] = 30'h202; entry_on[9] = 1;
    for (int e = 0; e < 3; e++) begin
      for (int k = 0; k < 4; k++) begin
        probe("R7 kind", 32'h800 + 32'(4 * e), 2'(k), 1, 1);
        chk("R7 kind grant", 32'(grant), 32'(k == e));
      end
    end
  endtask

  task automatic t_machine();
    clear_all();
    probe("R8 mmode empty", 32'h1234, 2'd1, 0, 1);
    chk("R8 mmode grant", 32'(grant), 1);
    bcfg[0] = 8'h10; bar[0] = 30'h48D; entry_on[0] = 1;
    probe("R8 mmode no rights", 32'h1234, 2'd1, 0, 1);
    chk("R8 mmode ignores rights", 32'(grant), 1);
    probe("R8 mmode veto", 32'h1234, 2'd1, 0, 0);
    chk("R8 mmode veto", 32'(grant), 0);
    bcfg[0] = C_WORD_RWX;
    probe("R9 super veto", 32'h1234, 2'd0, 1, 0);
    chk("R9 super veto", 32'({grant, hit_any, hit_idx}), 32'h10);
  endtask

  task automatic t_sidebits();
    clear_all();
    bcfg[6] = 8'hF1; bar[6] = 30'h300; entry_on[6] = 1;
    probe("R10 side bits load", 32'hC00, 2'd0, 1, 1);
    chk("R10 side bits load", 32'({grant, hit_any, hit_idx}), 32'h36);
    probe("R10 side bits store", 32'hC00, 2'd1, 1, 1);
    chk("R10 side bits store", 32'({grant, hit_any, hit_idx}), 32'h16);
    bcfg[6] = 8'hE0;
    probe("R10 side bits mode off", 32'hC00, 2'd0, 1, 1);
    chk("R10 side bits off", 32'(hit_any), 0);
  endtask

  task automatic t_sweep();
    void'($urandom(32'h5EED));
    for (int n = 0; n < 400; n++) begin
      if (n % 20 == 0) begin
        entry_on = 16'($urandom);
        for (int i = 0; i < NENT; i++) begin
          bcfg[i] = 8'($urandom);
          bar[i]  = {20'h00001, 10'($urandom)};
          if (($urandom & 3) == 0) bar[i][3:0] = 4'($urandom) | 4'h7;
        end
      end
      probe("R5 sweep", {12'h000, 2'b01, 16'($urandom) & 16'h0FFF, 2'($urandom)},
            2'($urandom), 1'($urandom), ($urandom % 5) != 0);
    end
  endtask

  initial begin
    clear_all();
    phys_addr = '0; acc_kind = '0; sup_mode = 1; mach_ok = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_switch();
    t_word();
    t_pow2();
    t_range();
    t_prio();
    t_perm();
    t_machine();
    t_sidebits();
    t_sweep();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule